// File: doc/BRIEF.md
# Two-Stage Supervisor Timeout Timer

This block watches a host processor for signs of life. The processor pulses one shared kick input. Two countdown stages restart on every kick: a short early-warning stage and a long last-resort stage. Each stage has its own timeout flag. A stage that runs down to zero before the next kick raises its flag and keeps it raised.

Both periods arrive on register inputs, counted in ticks of a free-running tick enable. Usually the early-warning stage gets the shorter period. The two stages never depend on each other, so an inverted setting is still valid. A period of zero switches a stage off.

The kick input may be asynchronous to the clock. It passes through two flops before its rising edge is taken. The reset is synchronous and active low.

Top module: `wd_ld_timer`

## Requirements
- R1: While reset is low, both flags read 0. On the first clock edge with reset high, each counter holds its programmed period. With tick held high, a stage of period P raises its flag on the P-th clock edge after reset is released, and not before.
- R2: A kick is a 0-to-1 transition of `kick_in`. The input is taken through two synchronising flops, and the reload happens on the third rising clock edge, counting the first edge that samples `kick_in` high. Holding `kick_in` high gives exactly one kick.
- R3: A counter decrements only on clock edges where `tick` is 1. A stage raises its flag on the edge that carries the P-th tick after a reload.
- R4: Once raised, a flag stays at 1 until a kick arrives or the stage is disabled.
- R5: A kick reloads both counters with their periods and clears both flags on the reload edge.
- R6: The two stages count independently. A long-stage period shorter than the short-stage period makes the long-stage flag rise first.
- R7: A period of 0 disables its stage. From the next clock edge on, that flag stays at 0.
- R8: A kick reloads the counters even when `tick` is 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable, one-cycle pulse per time unit |
| kick_in | input | 1 | Shared restart input, may be asynchronous |
| short_period | input | CNT_W | Early-warning period in ticks, 0 disables the stage |
| long_period | input | CNT_W | Last-resort period in ticks, 0 disables the stage |
| short_expired | output | 1 | Early-warning timeout flag |
| long_expired | output | 1 | Last-resort timeout flag |

## Verification
The main function is exercised with a set of period pairs:
- The normal ordering.
- The inverted ordering.
- One stage disabled.
- Both stages at period one.

Each pair is sampled just before and just at its expected expiry edge, which catches any off-by-one in the reload or expiry timing. Directed cases cover the remaining behaviour:
- The first expiry straight out of reset.
- A kick that arrives while `tick` is low.
- A `kick_in` held high, which separates edge detection from level sensing.
- A flag that must stay raised, and then clear on a later kick.
- A stage disabled while its flag is raised.

// File: rtl/wd_ld_timer.sv
module wd_ld_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick_in,
  input  logic [CNT_W-1:0] short_period,
  input  logic [CNT_W-1:0] long_period,
  output logic             short_expired,
  output logic             long_expired
);
  localparam int NSTG = 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [2:0] sync_q;
  logic       kick;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], kick_in};
  end

  assign kick = sync_q[1] & ~sync_q[2];

  logic [CNT_W-1:0] per_v [NSTG];
  logic [CNT_W-1:0] cnt_q [NSTG];
  logic [NSTG-1:0]  exp_q;

  assign per_v[0] = short_period;
  assign per_v[1] = long_period;

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= per_v[i];
        exp_q[i] <= 1'b0;
      end else if (per_v[i] == '0) begin
        cnt_q[i] <= '0;
        exp_q[i] <= 1'b0;
      end else if (kick) begin
        cnt_q[i] <= per_v[i];
        exp_q[i] <= 1'b0;
      end else if (tick && cnt_q[i] != '0) begin
        cnt_q[i] <= cnt_q[i] - ONE;
        if (cnt_q[i] == ONE) exp_q[i] <= 1'b1;
      end
    end

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q[i] && !kick && per_v[i] != '0 |=> exp_q[i]);
    a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !exp_q[i]);
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      per_v[i] == '0 |=> !exp_q[i]);
    a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_q[i]) |-> $past(tick));
  end

  a_r2_single_kick: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);

  assign short_expired = exp_q[0];
  assign long_expired  = exp_q[1];
endmodule

// File: tb/wd_ld_timer_test.sv
module wd_ld_timer_test;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, kick_in = 1'b0;
  logic [W-1:0] sp = '0, lp = '0;
  logic se, le;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wd_ld_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick_in(kick_in),
    .short_period(sp), .long_period(lp),
    .short_expired(se), .long_expired(le)
  );

  // wd period, ld period, edges after reload, expected short, expected long
  typedef struct packed { logic [15:0] wp; logic [15:0] lpv; logic [15:0] n; logic ew; logic el; } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{16'd4, 16'd10, 16'd3,  1'b0, 1'b0},
    '{16'd4, 16'd10, 16'd4,  1'b1, 1'b0},
    '{16'd4, 16'd10, 16'd9,  1'b1, 1'b0},
    '{16'd4, 16'd10, 16'd10, 1'b1, 1'b1},
    '{16'd6, 16'd3,  16'd3,  1'b0, 1'b1},
    '{16'd6, 16'd3,  16'd6,  1'b1, 1'b1},
    '{16'd0, 16'd5,  16'd20, 1'b0, 1'b1},
    '{16'd5, 16'd0,  16'd20, 1'b1, 1'b0},
    '{16'd1, 16'd1,  16'd1,  1'b1, 1'b1},
    '{16'd1, 16'd2,  16'd0,  1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drives a one-cycle pulse; returns just after the reload edge
  task automatic kick_pulse();
    kick_in = 1'b1;
    @(negedge clk);
    kick_in = 1'b0;
    cycles(2);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sp = 16'd3; lp = 16'd5; tick = 1'b1;
    cycles(3);
    check("R1 reset short", se, 1'b0);
    check("R1 reset long", le, 1'b0);
    rst_n = 1'b1;
    cycles(2);
    check("R1 short before expiry", se, 1'b0);
    cycles(1);
    check("R1 short at P", se, 1'b1);
    cycles(1);
    check("R1 long before expiry", le, 1'b0);
    cycles(1);
    check("R1 long at P", le, 1'b1);

    for (int v = 0; v < NV; v++) begin
      sp = VEC[v].wp; lp = VEC[v].lpv;
      cycles(2);
      kick_pulse();
      cycles(int'(VEC[v].n));
      check("R3/R6 short table", se, VEC[v].ew);
      check("R3/R6 long table", le, VEC[v].el);
    end

    // R8: kick with tick low, no counting while idle
    sp = 16'd3; lp = 16'd4; tick = 1'b0;
    cycles(2);
    kick_pulse();
    check("R5 R8 kick clears short", se, 1'b0);
    check("R8 kick clears long", le, 1'b0);
    cycles(30);
    check("R3 no tick no expiry", se, 1'b0);
    tick = 1'b1;
    cycles(3);
    check("R8 reload then 3 ticks", se, 1'b1);
    check("R8 long not yet", le, 1'b0);

    // R4: sticky, then R5 clear by kick
    cycles(20);
    check("R4 short sticky", se, 1'b1);
    check("R4 long sticky", le, 1'b1);
    kick_in = 1'b1;
    @(negedge clk);
    kick_in = 1'b0;
    cycles(1);
    check("R2 not yet reloaded", se, 1'b1);
    cycles(1);
    check("R5 cleared at reload edge", se, 1'b0);
    check("R5 long cleared", le, 1'b0);

    // R2: held level gives one kick only
    cycles(10);
    kick_in = 1'b1;
    cycles(3);
    check("R2 held reload clears", se, 1'b0);
    cycles(3);
    check("R2 held level no rekick", se, 1'b1);
    cycles(5);
    check("R2 held level long expires", le, 1'b1);
    kick_in = 1'b0;

    // R7: disable while raised
    sp = 16'd0;
    cycles(1);
    check("R7 disabled clears", se, 1'b0);
    check("R6 long unaffected", le, 1'b1);
    cycles(10);
    check("R7 stays low", se, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule